// File: doc/BRIEF.md
# Instruction Cycle Cost Calculator

This block sits beside the execution engine of a small 8-bit accumulator processor. For each instruction it works out the clock cycles that instruction costs and adds them to a running total. It also holds a cycle budget, so a host can run the core for a fixed slice of cycles and then hand control elsewhere.

The engine reports each finished instruction with a one-cycle strobe. With the strobe it gives a 3-bit cost class and two addresses. For an indexed or indirect-indexed read, the two addresses are the base address and the effective address. For a branch, they are the address of the offset byte and the branch target. A branch also carries a taken flag. The block compares the two addresses to find page-crossing penalties.

The host loads a new budget at each slice boundary. Any cycles past the old budget are kept as the starting count of the new slice.

Top module: `cycle_cost_unit`

## Requirements
- R1: While reset is held, and until the first strobe after reset, `cost_valid` is 0, `cycle_total` is 0 and the stored budget is 0. A stored budget of 0 means `slice_done` reads 1.
- R2: A branch (class 1) with `br_taken` = 0 costs 2 cycles, whatever the addresses are.
- R3: A taken branch (class 1, `br_taken` = 1) costs 3 cycles. It costs 4 when bit 8 of `eff_addr` differs from bit 8 of `base_addr`.
- R4: An indexed-absolute read (class 2) costs 4 cycles, and 5 when bit 8 of `eff_addr` differs from bit 8 of `base_addr`.
- R5: A post-indexed indirect read (class 3) costs 5 cycles, and 6 when bit 8 differs between the two addresses.
- R6: An indexed store (class 4) always costs 5 cycles, and an indexed read-modify-write (class 5) always costs 7 cycles. Neither adds a penalty when bit 8 differs.
- R7: Interrupt entry (class 6) costs 7 cycles. An unknown opcode (class 0) costs 2 cycles.
- R8: Class 7 costs the value given on `fixed_cyc`.
- R9: One clock edge after an edge that samples `instr_done` = 1, the following hold: `cost` shows that instruction's cost, `cost_valid` is 1 for exactly that cycle, and `cycle_total` has grown by that cost. Without a strobe, `cycle_total` keeps its value.
- R10: `slice_done` reads 1 exactly when `cycle_total` is at least the stored budget.
- R11: An edge that samples `slice_load` = 1 stores `budget_in` as the new budget. It also sets the count to the overrun against the old budget: total minus old budget, or 0 if the total was below it. A strobe on the same edge adds its cost on top of that overrun.
- R12: `cycle_total` saturates at 65535 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_done | input | 1 | One-cycle strobe: an instruction has completed |
| op_class | input | 3 | Cost class of the completed instruction |
| base_addr | input | 16 | Base address, or the address of the branch offset byte |
| eff_addr | input | 16 | Effective address, or the branch target |
| br_taken | input | 1 | The branch was taken |
| fixed_cyc | input | 4 | Cycle count used by class 7 |
| slice_load | input | 1 | Start a new slice with budget `budget_in` |
| budget_in | input | 16 | Budget for the new slice |
| cost | output | 4 | Cost of the last completed instruction |
| cost_valid | output | 1 | `cost` was updated this cycle |
| cycle_total | output | 16 | Running cycle count of the slice |
| slice_done | output | 1 | The count has reached the budget |

## Verification
Every registered result (`cost`, `cost_valid`, `cycle_total`, and `slice_done` derived from them) is due one clock edge after the edge that samples a strobe or a budget load. `slice_done` follows the total and budget registers with no further delay. The bench drives inputs on the falling edge. At the next falling edge it compares all outputs against a behavioural model that has been advanced by exactly one edge. A result that comes one cycle early or one cycle late therefore shows up as a mismatch.

// File: rtl/cost_pkg.sv
package cost_pkg;
  typedef enum logic [2:0] {
    CC_UNKNOWN = 3'd0,
    CC_BRANCH  = 3'd1,
    CC_IDX_RD  = 3'd2,
    CC_INDY_RD = 3'd3,
    CC_IDX_ST  = 3'd4,
    CC_IDX_RMW = 3'd5,
    CC_IRQ     = 3'd6,
    CC_FIXED   = 3'd7
  } cost_class_e;

  localparam int COST_W      = 4;
  localparam int CYC_UNKNOWN = 2;
  localparam int CYC_BR_NT   = 2;
  localparam int CYC_BR_T    = 3;
  localparam int CYC_IDX_RD  = 4;
  localparam int CYC_INDY_RD = 5;
  localparam int CYC_IDX_ST  = 5;
  localparam int CYC_IDX_RMW = 7;
  localparam int CYC_IRQ     = 7;
endpackage

// File: rtl/page_cross_detect.sv
module page_cross_detect #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BIT  = 8,
  parameter bit FULL_PAGE = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  output logic              crossed
);
  generate
    if (FULL_PAGE) begin : g_full
      assign crossed = (addr_a[ADDR_W-1:PAGE_BIT] != addr_b[ADDR_W-1:PAGE_BIT]);
    end else begin : g_bit
      assign crossed = addr_a[PAGE_BIT] ^ addr_b[PAGE_BIT];
    end
  endgenerate
endmodule

// File: rtl/cost_table.sv
module cost_table
  import cost_pkg::*;
(
  input  cost_class_e       cls,
  input  logic              crossed,
  input  logic              taken,
  input  logic [COST_W-1:0] fixed_cyc,
  output logic [COST_W-1:0] cost
);
  localparam logic [COST_W-1:0] ONE = COST_W'(1);

  always_comb begin
    unique case (cls)
      CC_BRANCH:  cost = taken ? (COST_W'(CYC_BR_T) + (crossed ? ONE : '0))
                               : COST_W'(CYC_BR_NT);
      CC_IDX_RD:  cost = COST_W'(CYC_IDX_RD) + (crossed ? ONE : '0);
      CC_INDY_RD: cost = COST_W'(CYC_INDY_RD) + (crossed ? ONE : '0);
      CC_IDX_ST:  cost = COST_W'(CYC_IDX_ST);
      CC_IDX_RMW: cost = COST_W'(CYC_IDX_RMW);
      CC_IRQ:     cost = COST_W'(CYC_IRQ);
      CC_FIXED:   cost = fixed_cyc;
      default:    cost = COST_W'(CYC_UNKNOWN);
    endcase
  end
endmodule

// File: rtl/slice_accum.sv
module slice_accum #(
  parameter int CNT_W  = 16,
  parameter int COST_W = 4
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              add_en,
  input  logic [COST_W-1:0] add_val,
  input  logic              load_en,
  input  logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  total,
  output logic              done
);
  localparam logic [CNT_W:0] SAT = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] total_q, total_d, budget_q, budget_d, base;
  logic [CNT_W:0]   sum;

  always_comb begin
    base = total_q;
    if (load_en) base = (total_q >= budget_q) ? (total_q - budget_q) : '0;
    sum      = {1'b0, base} + (add_en ? (CNT_W+1)'(add_val) : '0);
    total_d  = (sum > SAT) ? SAT[CNT_W-1:0] : sum[CNT_W-1:0];
    budget_d = load_en ? load_val : budget_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      total_q  <= '0;
      budget_q <= '0;
    end else begin
      if (add_en || load_en) total_q <= total_d;
      if (load_en)           budget_q <= budget_d;
    end
  end

  assign total = total_q;
  assign done  = (total_q >= budget_q);

  assert_no_wrap_R12: assert property (@(posedge clk) disable iff (!srst_n)
    !load_en |=> total >= $past(total));
  assert_load_shrinks_R11: assert property (@(posedge clk) disable iff (!srst_n)
    (load_en && !add_en) |=> total <= $past(total));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (!load_en && !add_en) |=> $stable(total));
endmodule

// File: rtl/cycle_cost_unit.sv
module cycle_cost_unit
  import cost_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 16,
  parameter int PAGE_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_done,
  input  logic [2:0]        op_class,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic              br_taken,
  input  logic [COST_W-1:0] fixed_cyc,
  input  logic              slice_load,
  input  logic [CNT_W-1:0]  budget_in,
  output logic [COST_W-1:0] cost,
  output logic              cost_valid,
  output logic [CNT_W-1:0]  cycle_total,
  output logic              slice_done
);
  logic [1:0]        rsync_q;
  logic              srst_n;
  logic              crossed;
  logic [COST_W-1:0] cost_comb, cost_q, cost_d;
  logic              vld_q, vld_d;
  cost_class_e       cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  assign cls = cost_class_e'(op_class);

  page_cross_detect #(.ADDR_W(ADDR_W), .PAGE_BIT(PAGE_BIT), .FULL_PAGE(1'b0)) u_cross (
    .addr_a(base_addr), .addr_b(eff_addr), .crossed(crossed)
  );

  cost_table u_table (
    .cls(cls), .crossed(crossed), .taken(br_taken),
    .fixed_cyc(fixed_cyc), .cost(cost_comb)
  );

  slice_accum #(.CNT_W(CNT_W), .COST_W(COST_W)) u_accum (
    .clk(clk), .srst_n(srst_n),
    .add_en(instr_done), .add_val(cost_comb),
    .load_en(slice_load), .load_val(budget_in),
    .total(cycle_total), .done(slice_done)
  );

  always_comb begin
    vld_d  = instr_done;
    cost_d = instr_done ? cost_comb : cost_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cost_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (instr_done) cost_q <= cost_d;
    end
  end

  assign cost       = cost_q;
  assign cost_valid = vld_q;

  assert_strobe_valid_R9: assert property (@(posedge clk) disable iff (!srst_n)
    instr_done |=> cost_valid);
  assert_no_strobe_R9: assert property (@(posedge clk) disable iff (!srst_n)
    !instr_done |=> !cost_valid);
  assert_branch_nt_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (instr_done && op_class == 3'd1 && !br_taken) |=> cost == 4'd2);
  assert_store_fixed_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (instr_done && op_class == 3'd4) |=> cost == 4'd5);
  assert_rmw_fixed_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (instr_done && op_class == 3'd5) |=> cost == 4'd7);
  assert_done_cause_R10: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(slice_done) |-> $past(instr_done || slice_load));
endmodule

// File: tb/sim_cycle_cost_unit.sv
module sim_cycle_cost_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, instr_done, br_taken, slice_load;
  logic [2:0]  op_class;
  logic [15:0] base_addr, eff_addr, budget_in;
  logic [3:0]  fixed_cyc;
  logic [3:0]  cost;
  logic        cost_valid, slice_done;
  logic [15:0] cycle_total;

  int checks = 0, failures = 0;
  bit finished = 0;
  int exp_tot = 0, exp_bud = 0, exp_cost = 0;
  bit exp_vld = 0;

  cycle_cost_unit u0 (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .op_class(op_class),
    .base_addr(base_addr), .eff_addr(eff_addr), .br_taken(br_taken),
    .fixed_cyc(fixed_cyc), .slice_load(slice_load), .budget_in(budget_in),
    .cost(cost), .cost_valid(cost_valid), .cycle_total(cycle_total),
    .slice_done(slice_done)
  );

  function automatic int ref_cost(int cls, logic [15:0] a, logic [15:0] b, bit tk, int fx);
    int x;
    x = (a[8] != b[8]) ? 1 : 0;
    case (cls)
      1: return tk ? 3 + x : 2;
      2: return 4 + x;
      3: return 5 + x;
      4: return 5;
      5: return 7;
      6: return 7;
      7: return fx;
      default: return 2;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(string req, bit ins, int cls, logic [15:0] a, logic [15:0] b,
                      bit tk, int fx, bit ld, int bud);
    int c;
    instr_done = ins; op_class = cls[2:0]; base_addr = a; eff_addr = b;
    br_taken = tk; fixed_cyc = fx[3:0]; slice_load = ld; budget_in = bud[15:0];
    c = ref_cost(cls, a, b, tk, fx);
    if (ld) begin
      exp_tot = (exp_tot >= exp_bud) ? exp_tot - exp_bud : 0;
      exp_bud = bud;
    end
    if (ins) begin
      exp_tot = exp_tot + c;
      if (exp_tot > 65535) exp_tot = 65535;
      exp_cost = c;
    end
    exp_vld = ins;
    @(posedge clk);
    @(negedge clk);
    instr_done = 0; slice_load = 0;
    chk({req, " valid R9"}, cost_valid, exp_vld);
    if (exp_vld) chk({req, " cost"}, cost, exp_cost);
    chk({req, " total R9"}, cycle_total, exp_tot);
    chk({req, " done R10"}, slice_done, exp_tot >= exp_bud);
  endtask

  task automatic idle(string req);
    step(req, 0, 0, 16'h0, 16'h0, 0, 0, 0, 0);
  endtask

  initial begin
    int guard = 0;
    while (!finished) begin
      @(posedge clk);
      guard++;
      if (guard > 150000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; instr_done = 0; slice_load = 0; op_class = 0; base_addr = 0;
    eff_addr = 0; br_taken = 0; fixed_cyc = 0; budget_in = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", cost_valid, 0);
    chk("R1 reset total", cycle_total, 0);
    chk("R1 reset done", slice_done, 1);
    rst_n = 1;
    repeat (3) idle("R1 idle");

    step("R11 load 40", 0, 0, 0, 0, 0, 0, 1, 40);
    step("R2 br nt", 1, 1, 16'h10FE, 16'h1203, 0, 0, 0, 0);
    step("R3 br t", 1, 1, 16'h1010, 16'h1020, 1, 0, 0, 0);
    step("R3 br t cross", 1, 1, 16'h10FE, 16'h1105, 1, 0, 0, 0);
    step("R4 idx rd", 1, 2, 16'h2010, 16'h2020, 0, 0, 0, 0);
    step("R4 idx rd cross", 1, 2, 16'h20F0, 16'h2110, 0, 0, 0, 0);
    idle("R9 hold");
    step("R5 indy", 1, 3, 16'h3000, 16'h3044, 0, 0, 0, 0);
    step("R5 indy cross", 1, 3, 16'h30FF, 16'h3100, 0, 0, 0, 0);
    step("R6 store cross", 1, 4, 16'h40F0, 16'h4110, 0, 0, 0, 0);
    step("R6 rmw cross", 1, 5, 16'h40F0, 16'h4110, 0, 0, 0, 0);
    step("R7 irq", 1, 6, 0, 0, 0, 0, 0, 0);
    step("R7 unknown", 1, 0, 16'h00FF, 16'h0100, 1, 0, 0, 0);
    step("R8 fixed", 1, 7, 0, 0, 0, 6, 0, 0);
    step("R8 fixed 13", 1, 7, 0, 0, 0, 13, 0, 0);
    idle("R10 done");
    step("R11 load+instr", 1, 6, 0, 0, 0, 0, 1, 100);
    step("R11 load under", 0, 0, 0, 0, 0, 0, 1, 8);
    for (int i = 0; i < 3; i++) step("R10 approach", 1, 2, 16'h0, 16'h0, 0, 0, 0, 0);

    step("R12 big budget", 0, 0, 0, 0, 0, 0, 1, 65535);
    for (int i = 0; i < 9400; i++) step("R12 fill", 1, 6, 0, 0, 0, 0, 0, 0);
    step("R12 sat", 1, 5, 0, 0, 0, 0, 0, 0);
    step("R11 after sat", 0, 0, 0, 0, 0, 0, 1, 100);
    idle("R10 end");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule